// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers four interrupt sources for a small CPU: one external pin and the overflow pulses of three timers (two 16-bit, one 8-bit). It keeps a sticky request flag and an enable bit for each source, plus one global enable. Once per instruction cycle, marked by a cycle strobe, it checks for a pending enabled request. If it finds one, it tells the CPU sequencer to take an interrupt and gives the vector address of the winning source.

Accepting an interrupt clears that source's flag and the global enable, so a second interrupt cannot nest while the first is served. If the return-address stack is full, acceptance waits and the flag stays set until a pop frees a level. A return-from-interrupt input turns the global enable back on. Software reads and writes the enables and flags through two 8-bit control registers.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both control registers read 0x00 and `take` is low.
- R2: Control register 0 (address 0) uses these bit positions: global enable at bit 0, enables for external, timer 0 and timer 1 at bits 1, 2 and 3, and flags for external, timer 0 and timer 1 at bits 4, 5 and 6. Bit 7 always reads 0.
- R3: Control register 1 (address 1) holds the timer 3 enable at bit 1 and the timer 3 flag at bit 5. All other bits read 0.
- R4: A one-cycle overflow pulse sets the matching flag on the next edge. The flag stays set until the interrupt is accepted or a register write clears it. A hardware set in the same cycle as a clear wins.
- R5: With the default edge setting, the external pin goes through a two-flop synchronizer, and only a falling edge sets the external flag. The flag is visible no more than four cycles after the pin changes, and a rising edge leaves it clear.
- R6: An interrupt is accepted only on a cycle where all of these hold: the cycle strobe is high, the global enable is set, some flag is set together with its enable, and the stack is not full. `take` is then high for exactly the following cycle.
- R7: When several requests are pending at once, the fixed priority order is external, timer 0, timer 1, timer 3. The vectors are 0x04, 0x08, 0x0C and 0x14.
- R8: Acceptance clears the flag of the source served and the global enable in the same edge. Other flags are kept, and they can still be set while the interrupt is being served.
- R9: While `stack_full` is high, no interrupt is accepted and the flags are kept. After it falls, the pending request is accepted on the next strobe.
- R10: A `reti` pulse sets the global enable on the next edge.
- R11: With the both-edges parameter set, a rising edge on the external pin also sets the external flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle strobe; requests are sampled when high |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = control 0, 1 = control 1 |
| reg_wdata | input | 8 | Register write data |
| stack_full | input | 1 | Return-address stack has no free level |
| reti | input | 1 | Return-from-interrupt; sets the global enable |
| take | output | 1 | One-cycle acknowledge request to the sequencer |
| vector | output | 13 | Vector address of the last accepted source |
| ctrl0_rd | output | 8 | Readback of control register 0 |
| ctrl1_rd | output | 8 | Readback of control register 1 |

## Verification
Directed sequences load all four flags at once and release them one at a time with `reti`. This confirms the priority order and the vector values, and shows that the global enable blocks nesting. Pin sequences with falling and rising edges separate the falling-only variant from the both-edges variant. A stack-full window placed over a pending request shows whether acceptance is held back while the flag is kept. A seeded random phase then mixes overflow pulses, strobes, stack-full windows, returns and register writes, and compares every cycle against a bench model. This exposes wrong set/clear precedence and acceptance on cycles that should be ignored.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt controller: source ordering and vectors.
// Assumes a 13-bit program address.
package irqc_pkg;
    localparam int NSRC  = 4;
    localparam int VEC_W = 13;

    // Source index doubles as priority rank (0 = highest).
    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_T0  = 2'd1,
        SRC_T1  = 2'd2,
        SRC_T3  = 2'd3
    } src_e;

    // Vector address for a given source index.
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        logic [VEC_W-1:0] v;
        if (idx < 3) v = VEC_W'((idx + 1) * 4);
        else         v = VEC_W'(20);
        return v;
    endfunction
endpackage

// File: rtl/irqc_edge_sync.sv
// Synchronizes the asynchronous external pin and produces a one-cycle
// edge pulse. BOTH_EDGES picks falling-only (0) or either edge (1).
// Assumes the pin idles high; the flops reset to 1.
module irqc_edge_sync #(
    parameter int STAGES     = 2,
    parameter bit BOTH_EDGES = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_pulse
);
    logic [STAGES:0] sh;
    logic cur, prev;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign cur  = sh[STAGES-1];
    assign prev = sh[STAGES];

    generate
        if (BOTH_EDGES) begin : g_both
            assign edge_pulse = cur ^ prev;
        end else begin : g_fall
            assign edge_pulse = prev & ~cur;
        end
    endgenerate
endmodule

// File: rtl/irqc_flag_bank.sv
// Holds the global enable, per-source enables and sticky request flags.
// Hardware set beats register write and acknowledge clear; reti beats all
// for the global enable. Assumes ack_vec is one-hot or zero.
module irqc_flag_bank
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_evt,
    input  logic            wr0,
    input  logic            wr1,
    input  logic [7:0]      wdata,
    input  logic            ack,
    input  logic [NSRC-1:0] ack_vec,
    input  logic            reti,
    output logic            gie,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] flg
);
    logic            gie_n;
    logic [NSRC-1:0] en_n, flg_n;

    // Next-state for enables and flags from writes, acks and events.
    always_comb begin
        gie_n = gie;
        en_n  = en;
        flg_n = flg;
        if (wr0) begin
            gie_n      = wdata[0];
            en_n[2:0]  = wdata[3:1];
            flg_n[2:0] = wdata[6:4];
        end
        if (wr1) begin
            en_n[3]  = wdata[1];
            flg_n[3] = wdata[5];
        end
        if (ack) begin
            gie_n = 1'b0;
            flg_n = flg_n & ~ack_vec;
        end
        if (reti) gie_n = 1'b1;
        flg_n = flg_n | set_evt;
    end

    // Register the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie <= 1'b0;
            en  <= '0;
            flg <= '0;
        end else begin
            gie <= gie_n;
            en  <= en_n;
            flg <= flg_n;
        end
    end

    // R4
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[1] |=> flg[1]);
    // R10
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> gie);
endmodule

// File: rtl/irqc_arbiter.sv
// Fixed-priority pick among pending enabled sources; lowest index wins.
// Purely combinational.
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]  pend,
    output logic             any,
    output logic [NSRC-1:0]  grant,
    output logic [VEC_W-1:0] vec
);
    // Scan from lowest priority up so the highest pending source wins.
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = vec_of(i);
            end
        end
        any = |pend;
    end

    // R7
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant));
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the interrupt controller: gathers events, holds flags, arbitrates
// once per strobed instruction cycle and issues a registered take/vector.
// Assumes overflow inputs are single-cycle pulses in the clk domain.
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter bit BOTH_EDGES  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             tmr3_ovf,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             stack_full,
    input  logic             reti,
    output logic             take,
    output logic [VEC_W-1:0] vector,
    output logic [7:0]       ctrl0_rd,
    output logic [7:0]       ctrl1_rd
);
    logic            ext_evt;
    logic [NSRC-1:0] set_evt, en, flg, grant;
    logic            gie, any, ack;
    logic [VEC_W-1:0] vec_sel;

    irqc_edge_sync #(.STAGES(SYNC_STAGES), .BOTH_EDGES(BOTH_EDGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .edge_pulse(ext_evt)
    );

    assign set_evt = {tmr3_ovf, tmr1_ovf, tmr0_ovf, ext_evt};

    irqc_arbiter u_arb (
        .pend(flg & en), .any(any), .grant(grant), .vec(vec_sel)
    );

    assign ack = cyc_en & gie & any & ~stack_full;

    irqc_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt),
        .wr0(reg_wr & ~reg_addr), .wr1(reg_wr & reg_addr), .wdata(reg_wdata),
        .ack(ack), .ack_vec(grant), .reti(reti),
        .gie(gie), .en(en), .flg(flg)
    );

    // Register the acknowledge strobe and latch the winning vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take   <= 1'b0;
            vector <= '0;
        end else begin
            take <= ack;
            if (ack) vector <= vec_sel;
        end
    end

    assign ctrl0_rd = {1'b0, flg[2:0], en[2:0], gie};
    assign ctrl1_rd = {2'b00, flg[3], 3'b000, en[3], 1'b0};

    // R6
    take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(cyc_en));
    // R9
    no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !$past(stack_full));
    // R8
    no_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !$past(reti) && !$past(reg_wr) |-> !ctrl0_rd[0]);
    // R6
    take_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !$past(reti) && !$past(reg_wr) |=> !take);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_en = 0, ext_pin = 1, t0 = 0, t1 = 0, t3 = 0;
    logic reg_wr = 0, reg_addr = 0, stack_full = 0, reti = 0;
    logic [7:0] reg_wdata = 0;
    logic take, take_b;
    logic [12:0] vector, vector_b;
    logic [7:0] c0, c1, c0_b, c1_b;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .tmr0_ovf(t0), .tmr1_ovf(t1), .tmr3_ovf(t3), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stack_full(stack_full),
        .reti(reti), .take(take), .vector(vector), .ctrl0_rd(c0), .ctrl1_rd(c1)
    );

    irq_vector_ctrl #(.BOTH_EDGES(1'b1)) u_dut_both (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .tmr0_ovf(t0), .tmr1_ovf(t1), .tmr3_ovf(t3), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stack_full(stack_full),
        .reti(reti), .take(take_b), .vector(vector_b), .ctrl0_rd(c0_b), .ctrl1_rd(c1_b)
    );

    // Bench model state (for timer/register traffic, pin held steady).
    logic m_gie, m_take;
    logic [3:0] m_en, m_flg;
    logic [12:0] m_vec;

    function automatic logic [12:0] exp_vec(input int i);
        return (i == 0) ? 13'h04 : (i == 1) ? 13'h08 : (i == 2) ? 13'h0C : 13'h14;
    endfunction

    function automatic logic [7:0] m_c0();
        return {1'b0, m_flg[2:0], m_en[2:0], m_gie};
    endfunction

    function automatic logic [7:0] m_c1();
        return {2'b0, m_flg[3], 3'b0, m_en[3], 1'b0};
    endfunction

    // Advance the model by one clock using the inputs currently applied.
    task automatic model_step();
        logic [3:0] pend, f;
        logic g, acc;
        int w;
        pend = m_flg & m_en;
        acc = cyc_en && m_gie && (pend != 0) && !stack_full;
        w = 0;
        for (int i = 3; i >= 0; i--) if (pend[i]) w = i;
        g = m_gie; f = m_flg;
        if (reg_wr && !reg_addr) begin
            g = reg_wdata[0]; m_en[2:0] = reg_wdata[3:1]; f[2:0] = reg_wdata[6:4];
        end
        if (reg_wr && reg_addr) begin
            m_en[3] = reg_wdata[1]; f[3] = reg_wdata[5];
        end
        if (acc) begin g = 0; f[w] = 0; m_vec = exp_vec(w); end
        if (reti) g = 1;
        f = f | {t3, t1, t0, 1'b0};
        m_gie = g; m_flg = f; m_take = acc;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic strobe();
        cyc_en = 1; step(); cyc_en = 0;
    endtask

    task automatic pulse_reti();
        reti = 1; step(); reti = 0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234));
        repeat (3) step();
        rst_n = 1; step();

        // R1 reset state
        check("R1 ctrl0", c0, 8'h00);
        check("R1 ctrl1", c1, 8'h00);
        check("R1 take", take, 0);

        // R2 / R3 layout
        wr(0, 8'hFF); check("R2 ctrl0 bit7 zero", c0, 8'h7F);
        wr(1, 8'hFF); check("R3 ctrl1 only bits 1,5", c1, 8'h22);
        wr(0, 8'h00); wr(1, 8'h00);
        check("R4 write clears", c0, 8'h00);

        // R4 sticky overflow flag
        t1 = 1; step(); t1 = 0;
        check("R4 t1 flag set", c0, 8'h40);
        repeat (3) step();
        check("R4 t1 flag sticky", c0, 8'h40);
        t3 = 1; step(); t3 = 0;
        check("R4 t3 flag set", c1, 8'h20);
        wr(0, 8'h00); wr(1, 8'h00);

        // R5 falling edge, R11 both edges
        ext_pin = 0; repeat (4) step();
        check("R5 falling sets ext flag", c0[4], 1);
        check("R11 falling sets ext flag (both)", c0_b[4], 1);
        wr(0, 8'h00);
        ext_pin = 1; repeat (4) step();
        check("R5 rising ignored", c0[4], 0);
        check("R11 rising sets ext flag", c0_b[4], 1);
        wr(0, 8'h00);

        // R7 / R8 priority walk
        wr(0, 8'h7F); wr(1, 8'h22);
        strobe();
        check("R6 take after strobe", take, 1);
        check("R7 ext vector", vector, 13'h04);
        check("R8 ext flag and gie cleared", c0, 8'h6E);
        strobe();
        check("R6 no take without gie", take, 0);
        pulse_reti();
        check("R10 reti sets gie", c0[0], 1);
        strobe(); check("R7 t0 vector", vector, 13'h08); check("R7 take t0", take, 1);
        pulse_reti(); strobe(); check("R7 t1 vector", vector, 13'h0C);
        pulse_reti(); strobe(); check("R7 t3 vector", vector, 13'h14);
        check("R8 t3 flag cleared", c1, 8'h02);
        pulse_reti();

        // R9 stack full hold-off
        t0 = 1; step(); t0 = 0;
        stack_full = 1; cyc_en = 1;
        repeat (3) begin step(); check("R9 held while full", take, 0); end
        check("R9 flag kept", c0[5], 1);
        stack_full = 0; step(); cyc_en = 0;
        check("R9 served after release", take, 1);
        check("R9 vector t0", vector, 13'h08);
        pulse_reti();

        // R6 disabled source not taken
        wr(0, 8'h41); strobe();
        check("R6 disabled source ignored", take, 0);
        wr(0, 8'h00); wr(1, 8'h00);

        // Random phase against model
        m_gie = 0; m_en = 0; m_flg = 0; m_take = 0; m_vec = vector;
        for (int n = 0; n < 3000; n++) begin
            cyc_en = ($urandom % 4) == 0;
            stack_full = ($urandom % 4) == 0;
            reti = ($urandom % 16) == 0;
            t0 = ($urandom % 8) == 0;
            t1 = ($urandom % 8) == 0;
            t3 = ($urandom % 8) == 0;
            reg_wr = ($urandom % 24) == 0;
            reg_addr = 1'($urandom);
            reg_wdata = 8'($urandom);
            model_step();
            step();
            check("R6 random take", take, m_take);
            if (m_take) check("R7 random vector", vector, m_vec);
            check("R4 random ctrl0", c0, m_c0());
            check("R3 random ctrl1", c1, m_c1());
        end
        cyc_en = 0; stack_full = 0; reti = 0; t0 = 0; t1 = 0; t3 = 0; reg_wr = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule